// File: doc/BRIEF.md
# Page Unmap and Write-Protect Guard

This block sits between a CPU's memory strobes and a local 64K RAM. It splits the address space into sixteen 4K pages and keeps two 16-bit masks, one bit per page in each. A set bit in the unmap mask stops the RAM from being selected for that page, so external target hardware can answer at those addresses instead. A set bit in the protect mask keeps the RAM selected for reads of that page but withholds its write strobe. No address translation takes place: the address passes to the RAM unchanged, and only select and write enables are gated.

Software loads each mask one byte at a time through four write-only I/O ports. When a write is blocked by protection, the block emits a one-cycle violation pulse for debug logic to capture.

Top module: `page_guard`

## Requirements
- R1: After reset both masks are zero, so every page is selected on `mem_req` and every write reaches `ram_we`.
- R2: The page index is `mem_addr[15:12]`. Bit n of a mask governs page n. `ram_sel` follows the current inputs in the same cycle and equals `mem_req` with the page's unmap bit clear.
- R3: The unmap mask takes `io_wdata` into bits 7:0 (pages 0 to 7) on an I/O write to port 0xF8, and into bits 15:8 (pages 8 to 15) on a write to port 0xF9. Writing one half leaves the other half unchanged. A bit value of 1 unmaps its page.
- R4: The protect mask takes bits 7:0 from port 0xFA and bits 15:8 from port 0xFB. On a page whose protect bit is 1, `ram_we` stays low while `ram_sel` still asserts.
- R5: `ram_we` is high only when `mem_wr` is high, the page is mapped and the page is unprotected. A write to an unmapped page asserts neither `ram_sel` nor `ram_we`.
- R6: An I/O write to any port other than 0xF8 to 0xFB, or data on the port lines while `io_wr` is low, leaves both masks unchanged.
- R7: A mask write takes effect at the clock edge that ends its cycle. A memory access in that same cycle is gated by the old mask.
- R8: When a write request (`mem_req` and `mem_wr`) first targets a mapped, protected page, `wr_viol` is high for exactly the one cycle after that clock edge. It does not pulse again while the same blocked request is held. It never pulses for writes to unmapped pages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_port | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| mem_req | input | 1 | Memory cycle in progress |
| mem_wr | input | 1 | Memory cycle is a write |
| mem_addr | input | 16 | Memory address |
| ram_sel | output | 1 | Local RAM select |
| ram_we | output | 1 | Local RAM write strobe |
| wr_viol | output | 1 | One-cycle pulse after a blocked write |

## Verification
Two functions can fall in the same cycle: a mask update on the I/O port and a memory write that the update concerns. The bench provokes this by writing the protect byte in the same cycle as a write to the page that byte covers. It expects `ram_we` high in that cycle under the old mask, and low in the next cycle with a single `wr_viol` pulse after it. The same pattern is repeated for unmapping, where `ram_sel` must drop only after the I/O edge.

// File: rtl/page_guard.sv
module page_guard #(
  parameter int          ADDR_W    = 16,
  parameter int          BYTE_W    = 8,
  parameter logic [7:0]  PORT_BASE = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [7:0]        io_port,
  input  logic [BYTE_W-1:0] io_wdata,
  input  logic              mem_req,
  input  logic              mem_wr,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              ram_sel,
  output logic              ram_we,
  output logic              wr_viol
);

  localparam int NPAGE  = 2 * BYTE_W;
  localparam int PAGE_W = $clog2(NPAGE);
  localparam logic [7:0] P_UNMAP_LO = PORT_BASE;
  localparam logic [7:0] P_UNMAP_HI = PORT_BASE + 8'd1;
  localparam logic [7:0] P_PROT_LO  = PORT_BASE + 8'd2;
  localparam logic [7:0] P_PROT_HI  = PORT_BASE + 8'd3;

  logic [NPAGE-1:0]  unmap_q, prot_q;
  logic [PAGE_W-1:0] pg;
  logic              pg_mapped, pg_prot, blk, blk_q, viol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unmap_q <= '0;
      prot_q  <= '0;
    end else if (io_wr) begin
      case (io_port)
        P_UNMAP_LO: unmap_q[BYTE_W-1:0]      <= io_wdata;
        P_UNMAP_HI: unmap_q[NPAGE-1:BYTE_W]  <= io_wdata;
        P_PROT_LO:  prot_q[BYTE_W-1:0]       <= io_wdata;
        P_PROT_HI:  prot_q[NPAGE-1:BYTE_W]   <= io_wdata;
        default: ;
      endcase
    end
  end

  assign pg        = mem_addr[ADDR_W-1 -: PAGE_W];
  assign pg_mapped = ~unmap_q[pg];
  assign pg_prot   = prot_q[pg];

  assign ram_sel = mem_req & pg_mapped;
  assign ram_we  = ram_sel & mem_wr & ~pg_prot;
  assign blk     = ram_sel & mem_wr & pg_prot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      blk_q  <= blk;
      viol_q <= blk & ~blk_q;
    end
  end

  assign wr_viol = viol_q;

  // R5
  we_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_sel && mem_wr && mem_req));

  // R4
  we_unprotected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !prot_q[mem_addr[ADDR_W-1 -: PAGE_W]]);

  // R3
  unmap_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_port == P_UNMAP_LO) |=>
      (unmap_q[BYTE_W-1:0] == $past(io_wdata) && $stable(unmap_q[NPAGE-1:BYTE_W])));

  // R4
  prot_hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_port == P_PROT_HI) |=>
      (prot_q[NPAGE-1:BYTE_W] == $past(io_wdata) && $stable(prot_q[BYTE_W-1:0])));

  // R6
  masks_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && (io_port == P_UNMAP_LO || io_port == P_UNMAP_HI ||
                io_port == P_PROT_LO  || io_port == P_PROT_HI))
      |=> ($stable(unmap_q) && $stable(prot_q)));

  // R8
  viol_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_viol |=> !wr_viol);

  // R8
  viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_viol) |-> $past(mem_req && mem_wr && !ram_we && ram_sel));

endmodule

// File: tb/sim_page_guard.sv
module sim_page_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_port = '0;
  logic [7:0]  io_wdata = '0;
  logic        mem_req = 1'b0;
  logic        mem_wr = 1'b0;
  logic [15:0] mem_addr = '0;
  logic        ram_sel, ram_we, wr_viol;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  page_guard u0 (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port(io_port), .io_wdata(io_wdata),
    .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .ram_sel(ram_sel), .ram_we(ram_we), .wr_viol(wr_viol)
  );

  // {addr, wr, exp_sel, exp_we} with unmap=16'h8005, protect=16'h0112
  localparam logic [18:0] VEC [12] = '{
    {16'h0123, 1'b0, 1'b0, 1'b0},
    {16'h1000, 1'b1, 1'b1, 1'b0},
    {16'h1FFF, 1'b0, 1'b1, 1'b0},
    {16'h2000, 1'b1, 1'b0, 1'b0},
    {16'h3ABC, 1'b1, 1'b1, 1'b1},
    {16'h4000, 1'b0, 1'b1, 1'b0},
    {16'h4FFF, 1'b1, 1'b1, 1'b0},
    {16'h8001, 1'b1, 1'b1, 1'b0},
    {16'h9000, 1'b1, 1'b1, 1'b1},
    {16'hF000, 1'b1, 1'b0, 1'b0},
    {16'hEFFF, 1'b1, 1'b1, 1'b1},
    {16'h7000, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic io_put(input logic [7:0] port, input logic [7:0] data);
    @(negedge clk);
    io_wr = 1'b1; io_port = port; io_wdata = data;
    @(negedge clk);
    io_wr = 1'b0; io_port = 8'h00; io_wdata = 8'h00;
  endtask

  task automatic mem_set(input logic req, input logic wr, input logic [15:0] a);
    mem_req = req; mem_wr = wr; mem_addr = a;
    #2;
  endtask

  task automatic sweep_all(input string tag, input logic [15:0] exp_sel, input logic [15:0] exp_we);
    for (int p = 0; p < 16; p++) begin
      mem_set(1'b1, 1'b1, 16'(p) << 12);
      chk(tag, {2'b00, ram_sel, ram_we}, {2'b00, exp_sel[p], exp_we[p]});
    end
    mem_set(1'b0, 1'b0, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, every page selected and writable
    sweep_all("R1 reset", 16'hFFFF, 16'hFFFF);
    mem_set(1'b0, 1'b1, 16'h5000);
    chk("R2 idle no select", {2'b00, ram_sel, ram_we}, 4'h0);

    // R3/R4 load masks
    io_put(8'hF8, 8'h05);
    io_put(8'hF9, 8'h80);
    io_put(8'hFA, 8'h12);
    io_put(8'hFB, 8'h01);

    // R2 R4 R5: vector table
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      mem_set(1'b1, VEC[i][2], VEC[i][18:3]);
      chk($sformatf("R2/R4/R5 vec %0d", i), {2'b00, ram_sel, ram_we}, {2'b00, VEC[i][1], VEC[i][0]});
    end
    mem_set(1'b0, 1'b0, 16'h0000);

    // R3: rewrite only high half, low half kept
    io_put(8'hF9, 8'h00);
    sweep_all("R3 half write", 16'hFFFA, 16'hFEE8);

    // R6: foreign ports and io_wr low leave masks unchanged
    io_put(8'hF7, 8'hFF);
    io_put(8'hFC, 8'hFF);
    io_put(8'hFE, 8'hFF);
    @(negedge clk);
    io_wr = 1'b0; io_port = 8'hF8; io_wdata = 8'hFF;
    @(negedge clk);
    io_port = 8'hFA;
    @(negedge clk);
    io_port = 8'h00; io_wdata = 8'h00;
    sweep_all("R6 ignored", 16'hFFFA, 16'hFEE8);

    // R8: held blocked write to page 1 pulses once
    @(negedge clk);
    mem_set(1'b1, 1'b1, 16'h1234);
    chk("R8 before edge", {3'b000, wr_viol}, 4'h0);
    @(negedge clk);
    chk("R8 pulse", {3'b000, wr_viol}, 4'h1);
    @(negedge clk);
    chk("R8 no repeat", {3'b000, wr_viol}, 4'h0);
    mem_set(1'b0, 1'b0, 16'h0000);
    @(negedge clk);
    chk("R8 idle", {3'b000, wr_viol}, 4'h0);

    // R8: unmapped write gives no pulse
    mem_set(1'b1, 1'b1, 16'h0100);
    @(negedge clk);
    mem_set(1'b0, 1'b0, 16'h0000);
    chk("R8 unmapped no pulse", {3'b000, wr_viol}, 4'h0);

    // R7: protect page 3 in the same cycle as a write to page 3
    @(negedge clk);
    io_wr = 1'b1; io_port = 8'hFA; io_wdata = 8'h1A;
    mem_set(1'b1, 1'b1, 16'h3000);
    chk("R7 old mask same cycle", {2'b00, ram_sel, ram_we}, 4'h3);
    @(negedge clk);
    io_wr = 1'b0; io_port = 8'h00; io_wdata = 8'h00;
    #2;
    chk("R7 new mask next cycle", {2'b00, ram_sel, ram_we}, 4'h2);
    chk("R8 not yet", {3'b000, wr_viol}, 4'h0);
    @(negedge clk);
    chk("R7/R8 pulse after switch", {3'b000, wr_viol}, 4'h1);
    mem_set(1'b0, 1'b0, 16'h0000);

    // R7: unmap page 6 during a read of it
    @(negedge clk);
    io_wr = 1'b1; io_port = 8'hF8; io_wdata = 8'h45;
    mem_set(1'b1, 1'b0, 16'h6000);
    chk("R7 unmap old", {2'b00, ram_sel, ram_we}, 4'h2);
    @(negedge clk);
    io_wr = 1'b0; io_port = 8'h00; io_wdata = 8'h00;
    #2;
    chk("R7 unmap new", {2'b00, ram_sel, ram_we}, 4'h0);
    mem_set(1'b0, 1'b0, 16'h0000);

    // R1: reset mid-run clears masks again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sweep_all("R1 re-reset", 16'hFFFF, 16'hFFFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule